// File: doc/BRIEF.md
# Cache Read Pipeline Engine

This block is the device side of a flash read path that keeps two page-wide register stages: a data register fed by the (modelled) array and a cache register that the host drains one byte at a time. A normal page read fills the data register while the block reports busy. Cache commands then move the data register into the cache register and, for the continuing form, start a background array read of the next row. The host drains the cache page while that background read runs, so most or all of the array latency stays out of sight.

Commands arrive already decoded as a two-bit opcode with a valid strobe and a row address. A command is only taken on a cycle where `busy` is low. Bytes leave through a valid/ready stream. A byte is transferred on every cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. `out_valid` may fall without a transfer only when the block turns busy for a new copy. The host may withhold `out_ready` for any length of time, which stalls the stream and nothing else. The array latency (`T_R`), the copy latency (`T_X`), the page size and the block size (in pages) are parameters.

Top module: `cache_read_engine`

## Requirements
- R1: After reset `busy`, `out_valid`, `err_boundary` and `err_illegal` are all 0.
- R2: Opcode 1 (page read) taken while idle holds `busy` high for exactly `T_R` cycles, clears both error flags, loads the addressed row into the data register, and leaves `out_valid` low until a cache command runs.
- R3: Opcode 2 (cache continue), taken when a page is pending and no array read is running, holds `busy` for exactly `T_X` cycles. It then presents the pending page from column 0 on the stream.
- R4: On completing an opcode 2 copy, the block starts an array read of row+1 into the data register. That read takes `T_R` cycles and does not raise `busy`, so the stream stays usable while it runs.
- R5: If opcode 2 or 3 is taken while that background read is still running, `busy` stays high until the read finishes and then for a further `T_X` cycles. The cache then holds the newly read row.
- R6: A cache command may be issued before the current cache page is fully drained. The stream restarts at column 0 of the new page.
- R7: Opcode 3 (cache last) copies the pending page like opcode 2 but starts no array read. A following opcode 2 or 3 is then treated as illegal.
- R8: If the row just copied is the last of its block (its low `BLK_BITS` bits are all ones), opcode 2 copies it but starts no array read. It also sets `err_boundary`, and a following cache command is treated as illegal.
- R9: Opcode 2 or 3 with no pending page is ignored. `busy` stays 0, the stream is unchanged, and `err_illegal` is set. Both error flags stay set until the next page read.
- R10: Commands presented while `busy` is high, and opcode 0 at any time, have no effect.
- R11: Stream rules. `out_data` is stable while `out_valid` is high and `out_ready` is low. One byte is consumed per handshake. `out_valid` is low after the last column of a page and while `busy` is high.
- R12: Byte at column c of row r is (29*r + 7*c + 90) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while busy is low |
| cmd_op | input | 2 | 0 none, 1 page read, 2 cache continue, 3 cache last |
| cmd_row | input | ROW_W | Row for a page read |
| busy | output | 1 | High while a foreground read or copy is in progress |
| out_valid | output | 1 | Cache byte available |
| out_ready | input | 1 | Host accepts the byte |
| out_data | output | 8 | Current cache byte |
| err_boundary | output | 1 | Background read suppressed at a block end |
| err_illegal | output | 1 | Cache command issued with no pending page |

## Verification
Counting from the clock edge that takes a command, `busy` falls `T_R` edges later for a page read and `T_X` edges later for a copy into an idle array. When the copy has to wait, `busy` falls at the background read's completion edge plus `T_X`. That completion edge is itself `T_R` edges after the copy that started it. The bench keeps its own edge counter, records the edge at which each background read must end, and from that predicts every busy length. It samples all outputs on the falling edge, counts busy cycles, and checks the first byte of the new page on the first idle sample. Stream bytes are compared on the falling edge before the handshake edge, and a byte held back by a low `out_ready` is checked again for stability on the next falling edge.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_PAGE = 2'd1,
    OP_NEXT = 2'd2,
    OP_LAST = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_COPY
  } st_e;

  // Content of the modelled array: one byte per (row, column).
  function automatic logic [7:0] cell_byte(input logic [31:0] row, input logic [31:0] col);
    logic [31:0] v;
    v = row * 32'd29 + col * 32'd7 + 32'd90;
    return v[7:0];
  endfunction

endpackage

// File: rtl/crd_array.sv
module crd_array
  import crd_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ROW_W      = 8,
  parameter int T_R        = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ROW_W-1:0]           start_row,
  output logic                       busy,
  output logic                       done,
  output logic [PAGE_BYTES-1:0][7:0] data_reg
);
  localparam int CW = (T_R > 1) ? $clog2(T_R) : 1;

  logic [CW-1:0]    cnt;
  logic             busy_q;
  logic [ROW_W-1:0] row_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt == '0);

  // A new start aborts any read in flight (a fresh page read may do this).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      row_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt    <= CW'(T_R - 1);
      row_q  <= start_row;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt <= cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_reg[i] <= '0;
      else if (done) data_reg[i] <= cell_byte(32'(row_q), 32'(i));
    end
  end

  // R4
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy_q || $past(start)));

endmodule

// File: rtl/crd_cache_out.sv
module crd_cache_out #(
  parameter int PAGE_BYTES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       clear,
  input  logic                       hold,
  input  logic [PAGE_BYTES-1:0][7:0] data_in,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_data
);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam int IW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

  logic [PAGE_BYTES-1:0][7:0] cache_q;
  logic [CW-1:0]              col;
  logic                       filled;
  logic                       at_end;
  logic [IW-1:0]              idx;

  assign at_end    = (col == CW'(PAGE_BYTES));
  assign idx       = col[IW-1:0];
  assign out_valid = filled && !at_end && !hold;
  assign out_data  = at_end ? 8'h00 : cache_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_q <= '0;
      col     <= '0;
      filled  <= 1'b0;
    end else if (load) begin
      cache_q <= data_in;
      col     <= '0;
      filled  <= 1'b1;
    end else if (clear) begin
      filled <= 1'b0;
    end else if (out_valid && out_ready) begin
      col <= col + 1'b1;
    end
  end

  // R11
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!out_valid || $stable(out_data)));
  // R11
  col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col <= CW'(PAGE_BYTES));

endmodule

// File: rtl/crd_ctrl.sv
module crd_ctrl
  import crd_pkg::*;
#(
  parameter int ROW_W    = 8,
  parameter int BLK_BITS = 2,
  parameter int T_X      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic             arr_busy,
  input  logic             arr_done,
  output logic             arr_start,
  output logic [ROW_W-1:0] arr_row,
  output logic             load_cache,
  output logic             clear_cache,
  output logic             busy,
  output logic             err_boundary,
  output logic             err_illegal
);
  localparam int XW = (T_X > 1) ? $clog2(T_X) : 1;
  localparam logic [BLK_BITS-1:0] BLK_LAST = '1;

  st_e              st, st_n;
  logic [XW-1:0]    xcnt, xcnt_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic             have_q, have_n;
  logic             last_q, last_n;
  logic             eb_q, eb_n;
  logic             ei_q, ei_n;
  op_e              op;
  logic             at_blk_end;

  assign op           = op_e'(cmd_op);
  assign at_blk_end   = (row_q[BLK_BITS-1:0] == BLK_LAST);
  assign busy         = (st != ST_IDLE);
  assign err_boundary = eb_q;
  assign err_illegal  = ei_q;

  always_comb begin
    st_n        = st;
    xcnt_n      = xcnt;
    row_n       = row_q;
    have_n      = have_q;
    last_n      = last_q;
    eb_n        = eb_q;
    ei_n        = ei_q;
    arr_start   = 1'b0;
    arr_row     = row_q;
    load_cache  = 1'b0;
    clear_cache = 1'b0;
    case (st)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (op)
            OP_PAGE: begin
              st_n        = ST_FETCH;
              arr_start   = 1'b1;
              arr_row     = cmd_row;
              row_n       = cmd_row;
              have_n      = 1'b1;
              eb_n        = 1'b0;
              ei_n        = 1'b0;
              clear_cache = 1'b1;
            end
            OP_NEXT, OP_LAST: begin
              if (!have_q) begin
                ei_n = 1'b1;
              end else begin
                last_n = (op == OP_LAST);
                if (arr_busy && !arr_done) begin
                  st_n = ST_WAIT;
                end else begin
                  st_n   = ST_COPY;
                  xcnt_n = XW'(T_X - 1);
                end
              end
            end
            default: ;
          endcase
        end
      end
      ST_FETCH: begin
        if (arr_done) st_n = ST_IDLE;
      end
      ST_WAIT: begin
        if (arr_done) begin
          st_n   = ST_COPY;
          xcnt_n = XW'(T_X - 1);
        end
      end
      ST_COPY: begin
        if (xcnt == '0) begin
          load_cache = 1'b1;
          st_n       = ST_IDLE;
          if (last_q) begin
            have_n = 1'b0;
          end else if (at_blk_end) begin
            eb_n   = 1'b1;
            have_n = 1'b0;
          end else begin
            row_n     = row_q + 1'b1;
            arr_start = 1'b1;
            arr_row   = row_q + 1'b1;
          end
        end else begin
          xcnt_n = xcnt - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      xcnt   <= '0;
      row_q  <= '0;
      have_q <= 1'b0;
      last_q <= 1'b0;
      eb_q   <= 1'b0;
      ei_q   <= 1'b0;
    end else begin
      st     <= st_n;
      xcnt   <= xcnt_n;
      row_q  <= row_n;
      have_q <= have_n;
      last_q <= last_n;
      eb_q   <= eb_n;
      ei_q   <= ei_n;
    end
  end

  // R2
  fetch_arr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |-> arr_busy);
  // R5
  wait_arr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> arr_busy);
  // R3
  copy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COPY) |-> !arr_busy);

endmodule

// File: rtl/cache_read_engine.sv
module cache_read_engine
  import crd_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ROW_W      = 8,
  parameter int BLK_BITS   = 2,
  parameter int T_R        = 20,
  parameter int T_X        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             err_boundary,
  output logic             err_illegal
);
  logic                       arr_start, arr_busy, arr_done;
  logic [ROW_W-1:0]           arr_row;
  logic                       load_cache, clear_cache;
  logic [PAGE_BYTES-1:0][7:0] data_reg;

  crd_ctrl #(.ROW_W(ROW_W), .BLK_BITS(BLK_BITS), .T_X(T_X)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .arr_busy(arr_busy), .arr_done(arr_done),
    .arr_start(arr_start), .arr_row(arr_row),
    .load_cache(load_cache), .clear_cache(clear_cache),
    .busy(busy), .err_boundary(err_boundary), .err_illegal(err_illegal)
  );

  crd_array #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .T_R(T_R)) u_array (
    .clk(clk), .rst_n(rst_n),
    .start(arr_start), .start_row(arr_row),
    .busy(arr_busy), .done(arr_done), .data_reg(data_reg)
  );

  crd_cache_out #(.PAGE_BYTES(PAGE_BYTES)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(load_cache), .clear(clear_cache), .hold(busy),
    .data_in(data_reg),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // R9
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_illegal) |-> $past(cmd_valid && cmd_op[1] && !busy));
  // R8
  boundary_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_boundary) |-> $past(busy));

endmodule

// File: tb/sim_cache_read_engine.sv
module sim_cache_read_engine;
  localparam int PB = 16;
  localparam int RW = 8;
  localparam int BB = 2;
  localparam int TR = 20;
  localparam int TX = 3;
  localparam int BMASK = (1 << BB) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [RW-1:0] cmd_row;
  logic          busy, out_valid, out_ready, err_boundary, err_illegal;
  logic [7:0]    out_data;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  // bench model
  int m_cur = 0, m_cache_row = 0, m_col = 0;
  bit m_have = 0, m_cvalid = 0, m_ebnd = 0, m_eill = 0;
  int bg_done = 0;

  cache_read_engine #(.PAGE_BYTES(PB), .ROW_W(RW), .BLK_BITS(BB), .T_R(TR), .T_X(TX)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err_boundary(err_boundary), .err_illegal(err_illegal)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int exp_byte(int row, int col);
    return (row * 29 + col * 7 + 90) & 255;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic send(int op, int row);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_row   = RW'(row);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_page(int row);
    int n;
    send(1, row);
    count_busy(n);
    chk(n == TR, "R2 page-read busy", n, TR);
    m_cur = row; m_have = 1; m_cvalid = 0; m_ebnd = 0; m_eill = 0; bg_done = 0;
    chk(out_valid == 1'b0, "R2 no stream after page read", int'(out_valid), 0);
    chk(err_illegal == 1'b0 && err_boundary == 1'b0, "R9 flags cleared by page read",
        int'({err_boundary, err_illegal}), 0);
  endtask

  task automatic do_cache(bit last);
    int n, a, expn;
    string rq;
    rq = last ? "R7" : "R3";
    a = cyc + 1;
    send(last ? 3 : 2, 0);
    if (!m_have) begin
      chk(busy == 1'b0, "R9 illegal cache cmd keeps idle", int'(busy), 0);
      chk(err_illegal == 1'b1, last ? "R7 illegal flag" : "R9 illegal flag", int'(err_illegal), 1);
      chk(out_valid == (m_cvalid && m_col < PB), "R9 stream unchanged",
          int'(out_valid), int'(m_cvalid && m_col < PB));
      if (out_valid) chk(int'(out_data) == exp_byte(m_cache_row, m_col), "R9 stream byte unchanged",
                         int'(out_data), exp_byte(m_cache_row, m_col));
      m_eill = 1;
      return;
    end
    expn = (bg_done > a) ? (bg_done - a) + TX : TX;
    count_busy(n);
    chk(n == expn, (expn > TX) ? "R5 busy waits for array" : {rq, " copy busy"}, n, expn);
    m_cache_row = m_cur; m_col = 0; m_cvalid = 1;
    if (last) m_have = 0;
    else if ((m_cur & BMASK) == BMASK) begin m_ebnd = 1; m_have = 0; end
    else begin m_cur++; bg_done = cyc + TR; end
    chk(out_valid == 1'b1, {rq, " stream after copy"}, int'(out_valid), 1);
    chk(int'(out_data) == exp_byte(m_cache_row, 0), "R6 restart at column 0",
        int'(out_data), exp_byte(m_cache_row, 0));
    chk(err_boundary == m_ebnd, "R8 boundary flag", int'(err_boundary), int'(m_ebnd));
  endtask

  task automatic drain(int nbytes);
    int got = 0;
    bit prev_hold = 0;
    int prev_data = 0;
    while (got < nbytes && m_cvalid && m_col < PB) begin
      bit r;
      chk(out_valid == 1'b1, "R4 stream usable during background read", int'(out_valid), 1);
      chk(int'(out_data) == exp_byte(m_cache_row, m_col), "R12 byte value",
          int'(out_data), exp_byte(m_cache_row, m_col));
      if (prev_hold) chk(int'(out_data) == prev_data, "R11 held byte stable", int'(out_data), prev_data);
      r = ($urandom % 3) != 0;
      out_ready = r;
      prev_data = int'(out_data);
      @(negedge clk);
      if (r) begin m_col++; got++; end
      prev_hold = !r;
    end
    out_ready = 1'b0;
    if (m_cvalid && m_col == PB)
      chk(out_valid == 1'b0, "R11 valid low after last column", int'(out_valid), 0);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_row = '0; out_ready = 1'b0;
    void'($urandom(32'd7713));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 reset outputs", int'({busy, out_valid}), 0);
    chk(err_boundary == 1'b0 && err_illegal == 1'b0, "R1 reset flags",
        int'({err_boundary, err_illegal}), 0);

    // R9: cache commands before any page read
    do_cache(0);
    do_cache(1);

    // R10: opcode 0 does nothing
    send(0, 5);
    chk(busy == 1'b0 && out_valid == 1'b0, "R10 opcode 0 ignored", int'({busy, out_valid}), 0);

    // Directed pipeline walk through a block: rows 4..7
    do_page(4);
    do_cache(0);
    drain(PB);
    do_cache(0);
    do_cache(0);          // R5: issued at once, background read still running
    drain(5);
    do_cache(0);          // R6 partial drain, R8 row 7 ends the block
    drain(PB);
    do_cache(0);          // illegal after boundary

    // R10: command while busy is ignored
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_row = RW'(9);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 3) begin cmd_valid = 1'b1; cmd_op = 2'd2; end
      else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_op = 2'd0;
    chk(n == TR, "R10 busy unchanged by command during busy", n, TR);
    chk(out_valid == 1'b0 && err_illegal == 1'b0, "R10 no copy and no flag",
        int'({out_valid, err_illegal}), 0);
    m_cur = 9; m_have = 1; m_cvalid = 0; m_ebnd = 0; m_eill = 0; bg_done = 0;

    // R7: last page, then further cache commands are illegal
    do_cache(1);
    drain(6);
    do_cache(0);
    drain(PB);

    // Random sessions
    for (int s = 0; s < 14; s++) begin
      int k;
      do_page(int'($urandom % 256));
      k = int'($urandom % 6) + 1;
      for (int j = 0; j < k; j++) begin
        do_cache((j == k - 1) && ($urandom % 2 == 1));
        drain(int'($urandom % (PB + 1)));
        repeat ($urandom % 25) @(negedge clk);
      end
    end

    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete, actual=%0d expected=<150000 cycles", cyc);
    report();
    $finish;
  end

endmodule